// File: doc/BRIEF.md
# Polled Mailbox Write Engine

This block posts one command into a three-register mailbox and can then wait for the far side to act on it. When it gets a start strobe, it captures a 32-bit command word, a 64-bit payload and three time limits. It then writes the payload and the command to the mailbox through a simple register master port. That port is a valid/ready request channel with one read response channel.

When polling is enabled, the engine first reads the interface register until its acceptance flag is set. It then reads the low data word until its completion flag is set. If completion does not arrive within one poll interval, the interval is added to a budget and the whole mailbox is written again. When the budget reaches the total limit, the operation ends with a failure. All times are counted in pulses of an external one-microsecond tick. The command is passed through without being interpreted.

At the end the engine pulses `done` for one cycle. It then holds `ok` and the reason code `err` until the next start.

Top module: `mbox_poll_writer`

## Requirements
- R1: Each round issues exactly three writes in this fixed order: the payload bits [31:0] to the low data address (`LO_ADDR`), the payload bits [63:32] to the high data address (`HI_ADDR`), and the command word to the interface address (`CMD_ADDR`).
- R2: When the captured total limit or the captured poll interval is zero, the operation ends with `ok`=1 and `err`=0 right after the command write, and no read is issued.
- R3: After the writes, the engine reads `CMD_ADDR` until bit 31 of the response is 1. If an unset response arrives after `busy_to` ticks have elapsed in this phase, the operation ends with `ok`=0 and `err`=1.
- R4: After acceptance, the engine reads `LO_ADDR`. A response with bit 0 set ends the operation with `ok`=1 and `err`=0.
- R5: When `poll_int` ticks have elapsed in the completion phase without bit 0 being seen, `poll_int` is added to an accumulated wait. The operation then ends with `ok`=0 and `err`=2 once the accumulated wait is greater than or equal to `total_to`; otherwise the engine starts another round at R1.
- R6: At most one read is outstanding. No new request is issued until the read response (`rsp_valid`) has been received.
- R7: A start strobe while `busy` is high has no effect. A start while idle raises `busy` on the next cycle.
- R8: `done` is a one-cycle pulse that appears one cycle after the final bus event (the last write handshake or the deciding read response). `ok` and `err` hold their values until the next accepted start, which clears both.
- R9: A synchronous active-high `rst` returns the engine to idle with `busy`, `done`, `ok`, `err` and `req_valid` all at 0.
- R10: While `req_valid` is high and `req_ready` is low, the request (write flag, address, write data) stays unchanged and `req_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (ignored while busy) |
| cmd | input | 32 | Command word, captured at start |
| value | input | 64 | Payload, captured at start |
| busy_to | input | TW | Acceptance limit in ticks |
| poll_int | input | TW | Completion poll interval in ticks |
| total_to | input | TW | Total completion budget in ticks |
| us_tick | input | 1 | One-microsecond tick pulse |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| ok | output | 1 | Last operation succeeded |
| err | output | 2 | Reason code: 0 none, 1 acceptance timeout, 2 total timeout |
| req_valid | output | 1 | Register request valid |
| req_ready | input | 1 | Register request accepted |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Register address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read response valid |
| rsp_rdata | input | 32 | Read response data |

Back-pressure rule: a request is taken on a cycle in which `req_valid` and `req_ready` are both high. Until that cycle the request is held unchanged. Read responses cannot be stalled.

## Verification
Each bus event, whether a request handshake or a read response, is settled on the clock edge that follows it. `done`, `ok` and `err` therefore change exactly one cycle after the final event. The bench logs the cycle of every event at the falling edge and requires `done` to be seen at the falling edge one cycle later. The status is checked on the cycle after start, and again a few cycles after `done`. The write sequence is compared in order against a scoreboard queue, so the number of rounds (ceil of total over interval) is checked exactly regardless of stall patterns.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WR_LO,
    S_WR_HI,
    S_WR_CMD,
    S_BSY_REQ,
    S_BSY_WAIT,
    S_ACK_REQ,
    S_ACK_WAIT
  } mbw_state_e;

  localparam logic [1:0] ERR_NONE  = 2'd0;
  localparam logic [1:0] ERR_BUSY  = 2'd1;
  localparam logic [1:0] ERR_TOTAL = 2'd2;

  localparam int ACCEPT_BIT = 31;
  localparam int FINISH_BIT = 0;
endpackage

// File: rtl/mbw_tick_timer.sv
module mbw_tick_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          run,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  localparam logic [TW-1:0] CNT_MAX = '1;

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run && tick && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);
endmodule

// File: rtl/mbw_budget.sv
module mbw_budget #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          add,
  input  logic [TW-1:0] amt,
  input  logic [TW-1:0] total,
  output logic          exhausted
);
  localparam int AW = TW + 1;

  logic [AW-1:0] acc;
  logic [AW-1:0] sum;

  assign sum       = acc + {1'b0, amt};
  assign exhausted = (sum >= {1'b0, total});

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (add) acc <= sum;
  end
endmodule

// File: rtl/mbw_seq.sv
module mbw_seq
  import mbw_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                TW       = 16,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 'h24,
  parameter logic [ADDR_W-1:0] LO_ADDR  = 'h28,
  parameter logic [ADDR_W-1:0] HI_ADDR  = 'h2C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       cmd,
  input  logic [63:0]       value,
  input  logic [TW-1:0]     busy_to,
  input  logic [TW-1:0]     poll_int,
  input  logic [TW-1:0]     total_to,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [31:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_rdata,
  output logic              tmr_clr,
  output logic              tmr_run,
  output logic [TW-1:0]     tmr_limit,
  input  logic              tmr_expired,
  output logic              bud_clr,
  output logic              bud_add,
  output logic [TW-1:0]     bud_amt,
  output logic [TW-1:0]     bud_total,
  input  logic              bud_exhausted,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic [1:0]        err
);
  mbw_state_e    state, nxt;
  logic [31:0]   cmd_q;
  logic [63:0]   val_q;
  logic [TW-1:0] bto_q, pint_q, tot_q;
  logic          done_q, ok_q;
  logic [1:0]    err_q;
  logic          hs, nopoll, fin, fin_ok;
  logic [1:0]    fin_err;
  logic          unused_rdata;

  assign unused_rdata = ^rsp_rdata;
  assign hs     = req_valid && req_ready;
  assign nopoll = (tot_q == '0) || (pint_q == '0);

  always_comb begin
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = CMD_ADDR;
    req_wdata = '0;
    unique case (state)
      S_WR_LO:   begin req_valid = 1'b1; req_write = 1'b1; req_addr = LO_ADDR;  req_wdata = val_q[31:0];  end
      S_WR_HI:   begin req_valid = 1'b1; req_write = 1'b1; req_addr = HI_ADDR;  req_wdata = val_q[63:32]; end
      S_WR_CMD:  begin req_valid = 1'b1; req_write = 1'b1; req_addr = CMD_ADDR; req_wdata = cmd_q;        end
      S_BSY_REQ: begin req_valid = 1'b1; req_addr = CMD_ADDR; end
      S_ACK_REQ: begin req_valid = 1'b1; req_addr = LO_ADDR;  end
      default:   ;
    endcase
  end

  assign tmr_run   = (state == S_BSY_REQ) || (state == S_BSY_WAIT) ||
                     (state == S_ACK_REQ) || (state == S_ACK_WAIT);
  assign tmr_limit = ((state == S_BSY_REQ) || (state == S_BSY_WAIT)) ? bto_q : pint_q;
  assign bud_amt   = pint_q;
  assign bud_total = tot_q;

  always_comb begin
    nxt     = state;
    tmr_clr = 1'b0;
    bud_clr = 1'b0;
    bud_add = 1'b0;
    fin     = 1'b0;
    fin_ok  = 1'b0;
    fin_err = ERR_NONE;
    unique case (state)
      S_IDLE: if (start) begin nxt = S_WR_LO; bud_clr = 1'b1; end
      S_WR_LO: if (hs) nxt = S_WR_HI;
      S_WR_HI: if (hs) nxt = S_WR_CMD;
      S_WR_CMD: if (hs) begin
        if (nopoll) begin
          nxt = S_IDLE; fin = 1'b1; fin_ok = 1'b1;
        end else begin
          nxt = S_BSY_REQ; tmr_clr = 1'b1;
        end
      end
      S_BSY_REQ: if (hs) nxt = S_BSY_WAIT;
      S_BSY_WAIT: if (rsp_valid) begin
        if (rsp_rdata[ACCEPT_BIT]) begin
          nxt = S_ACK_REQ; tmr_clr = 1'b1;
        end else if (tmr_expired) begin
          nxt = S_IDLE; fin = 1'b1; fin_err = ERR_BUSY;
        end else begin
          nxt = S_BSY_REQ;
        end
      end
      S_ACK_REQ: if (hs) nxt = S_ACK_WAIT;
      S_ACK_WAIT: if (rsp_valid) begin
        if (rsp_rdata[FINISH_BIT]) begin
          nxt = S_IDLE; fin = 1'b1; fin_ok = 1'b1;
        end else if (tmr_expired) begin
          bud_add = 1'b1;
          if (bud_exhausted) begin
            nxt = S_IDLE; fin = 1'b1; fin_err = ERR_TOTAL;
          end else begin
            nxt = S_WR_LO;
          end
        end else begin
          nxt = S_ACK_REQ;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cmd_q  <= '0;
      val_q  <= '0;
      bto_q  <= '0;
      pint_q <= '0;
      tot_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= ERR_NONE;
    end else begin
      state  <= nxt;
      done_q <= fin;
      if (state == S_IDLE && start) begin
        cmd_q  <= cmd;
        val_q  <= value;
        bto_q  <= busy_to;
        pint_q <= poll_int;
        tot_q  <= total_to;
        ok_q   <= 1'b0;
        err_q  <= ERR_NONE;
      end
      if (fin) begin
        ok_q  <= fin_ok;
        err_q <= fin_err;
      end
    end
  end

  assign busy = (state != S_IDLE);
  assign done = done_q;
  assign ok   = ok_q;
  assign err  = err_q;
endmodule

// File: rtl/mbox_poll_writer.sv
module mbox_poll_writer #(
  parameter int                ADDR_W   = 8,
  parameter int                TW       = 16,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 'h24,
  parameter logic [ADDR_W-1:0] LO_ADDR  = 'h28,
  parameter logic [ADDR_W-1:0] HI_ADDR  = 'h2C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       cmd,
  input  logic [63:0]       value,
  input  logic [TW-1:0]     busy_to,
  input  logic [TW-1:0]     poll_int,
  input  logic [TW-1:0]     total_to,
  input  logic              us_tick,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic [1:0]        err,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [31:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_rdata
);
  logic          tmr_clr, tmr_run, tmr_expired;
  logic [TW-1:0] tmr_limit;
  logic          bud_clr, bud_add, bud_exhausted;
  logic [TW-1:0] bud_amt, bud_total;

  mbw_seq #(
    .ADDR_W(ADDR_W), .TW(TW),
    .CMD_ADDR(CMD_ADDR), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .value(value),
    .busy_to(busy_to), .poll_int(poll_int), .total_to(total_to),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .tmr_clr(tmr_clr), .tmr_run(tmr_run), .tmr_limit(tmr_limit),
    .tmr_expired(tmr_expired),
    .bud_clr(bud_clr), .bud_add(bud_add), .bud_amt(bud_amt),
    .bud_total(bud_total), .bud_exhausted(bud_exhausted),
    .busy(busy), .done(done), .ok(ok), .err(err)
  );

  mbw_tick_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .run(tmr_run), .tick(us_tick),
    .limit(tmr_limit), .expired(tmr_expired)
  );

  mbw_budget #(.TW(TW)) u_bud (
    .clk(clk), .rst(rst), .clr(bud_clr), .add(bud_add), .amt(bud_amt),
    .total(bud_total), .exhausted(bud_exhausted)
  );
endmodule

// File: rtl/mbw_checker.sv
module mbw_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              ok,
  input logic [1:0]        err,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid
);
  logic rd_open;

  always_ff @(posedge clk) begin
    if (rst) rd_open <= 1'b0;
    else if (req_valid && req_ready && !req_write) rd_open <= 1'b1;
    else if (rsp_valid) rd_open <= 1'b0;
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_write) &&
                                   $stable(req_addr) && $stable(req_wdata)));

  assert_one_read_R6: assert property (@(posedge clk) disable iff (rst)
    rd_open |-> !req_valid);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_status_excl_R8: assert property (@(posedge clk) disable iff (rst)
    ok |-> (err == 2'd0));

  assert_start_takes_R7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !req_valid);
endmodule

bind mbox_poll_writer mbw_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_mbox_poll_writer.sv
module sim_mbox_poll_writer;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int TW = 16;
  localparam logic [7:0] A_CMD = 8'h24;
  localparam logic [7:0] A_LO  = 8'h28;
  localparam logic [7:0] A_HI  = 8'h2C;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, us_tick = 1'b0;
  logic [31:0] cmd = '0;
  logic [63:0] value = '0;
  logic [TW-1:0] busy_to = '0, poll_int = '0, total_to = '0;
  logic busy, done, ok, req_valid, req_write;
  logic [1:0] err;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata = '0;
  logic req_ready = 1'b0, rsp_valid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_poll_writer #(.ADDR_W(ADDR_W), .TW(TW)) u0 (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .value(value),
    .busy_to(busy_to), .poll_int(poll_int), .total_to(total_to), .us_tick(us_tick),
    .busy(busy), .done(done), .ok(ok), .err(err),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  int checks = 0, errors = 0;
  int cyc = 0, last_evt = 0, reads = 0, rounds = 0, cmd_reads = 0, dones = 0;
  int busy_lag = 0, done_round = 1, tick_div = 2;
  bit stall = 0, pend = 0;
  logic [31:0] pend_data = '0, m_lo = '0, m_cmd = '0;
  logic [7:0]  exp_addr[$];
  logic [31:0] exp_data[$];
  logic [2:0]  exp_res[$];

  task automatic chk(input bit good, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bus model and monitor, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    us_tick = (cyc % tick_div) == 0;
    if (rst) begin
      pend = 0; rsp_valid = 1'b0; req_ready = 1'b0;
    end else begin
      if (done) begin
        dones++;
        if (exp_res.size() == 0) chk(0, "R7", "unexpected done", 1, 0);
        else begin
          logic [2:0] e;
          e = exp_res.pop_front();
          chk({ok, err} == e, "R8", "ok/err at done", {ok, err}, e);
          chk(cyc - last_evt == 1, "R8", "done latency", cyc - last_evt, 1);
        end
      end
      rsp_valid = 1'b0;
      if (pend) begin
        rsp_valid = 1'b1; rsp_rdata = pend_data; pend = 0; last_evt = cyc;
      end
      req_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      if (req_valid && req_ready) begin
        last_evt = cyc;
        if (req_write) begin
          if (exp_addr.size() == 0) chk(0, "R1", "unexpected write", req_addr, 0);
          else begin
            logic [7:0] ea;
            logic [31:0] ed;
            ea = exp_addr.pop_front();
            ed = exp_data.pop_front();
            chk(req_addr == ea, "R1", "write address", req_addr, ea);
            chk(req_wdata == ed, "R1", "write data", req_wdata, ed);
          end
          if (req_addr == A_LO) m_lo = req_wdata;
          if (req_addr == A_CMD) begin m_cmd = req_wdata; rounds++; cmd_reads = 0; end
        end else begin
          reads++;
          pend = 1;
          if (req_addr == A_CMD) begin
            pend_data = {(cmd_reads >= busy_lag) ? 1'b1 : 1'b0, m_cmd[30:0]};
            cmd_reads++;
          end else begin
            pend_data = {m_lo[31:1], (done_round != 0 && rounds >= done_round) ? 1'b1 : 1'b0};
          end
        end
      end
    end
  end

  // driver: queue expectations, then pulse start
  task automatic run_op(input logic [31:0] c, input logic [63:0] v,
                        input int bto, input int pint, input int tot,
                        input int nround, input logic [2:0] res, input string req);
    int d0;
    for (int i = 0; i < nround; i++) begin
      exp_addr.push_back(A_LO);  exp_data.push_back(v[31:0]);
      exp_addr.push_back(A_HI);  exp_data.push_back(v[63:32]);
      exp_addr.push_back(A_CMD); exp_data.push_back(c);
    end
    exp_res.push_back(res);
    d0 = dones;
    rounds = 0;
    @(negedge clk);
    cmd = c; value = v; busy_to = TW'(bto); poll_int = TW'(pint); total_to = TW'(tot);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !ok && err == 2'd0, "R8", "status cleared at start", {busy, ok, err}, 3'b100);
    for (int w = 0; w < 5000 && dones == d0; w++) @(negedge clk);
    chk(dones == d0 + 1, req, "operation finished", dones - d0, 1);
    chk(exp_addr.size() == 0, "R1", "all round writes seen", exp_addr.size(), 0);
    repeat (3) @(negedge clk);
    chk({ok, err} == res, "R8", "status held", {ok, err}, res);
    exp_addr.delete(); exp_data.delete(); exp_res.delete();
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(negedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    chk(!busy && !done && !ok && err == 0 && !req_valid, "R9", "reset state",
        {busy, done, ok, err, req_valid}, 0);
    rst = 1'b0;

    begin
      int r0;
      r0 = reads;
      // R2: zero total -> no polling
      run_op(32'h8000_0007, 64'h1_0000_0003, 10, 5, 0, 1, 3'b100, "R2");
      chk(reads == r0, "R2", "no reads with zero total", reads - r0, 0);
      r0 = reads;
      // R2: zero interval -> no polling
      run_op(32'h8000_0011, 64'hAAAA_5555_0000_0001, 10, 0, 10, 1, 3'b100, "R2");
      chk(reads == r0, "R2", "no reads with zero interval", reads - r0, 0);
    end

    // R3/R4: acceptance after three unset reads, completion in round 1
    busy_lag = 3; done_round = 1;
    run_op(32'h8000_0007, 64'h0000_0000_0000_0003, 20, 5, 20, 1, 3'b100, "R4");

    // R3: acceptance never set -> busy timeout
    busy_lag = 1000; done_round = 1;
    run_op(32'h1234_5678, 64'hDEAD_BEEF_CAFE_F00D, 4, 5, 20, 1, {1'b0, 2'd1}, "R3");

    // R5: completion never, total equals two intervals -> two rounds
    busy_lag = 0; done_round = 0;
    run_op(32'h0BAD_F00D, 64'h0123_4567_89AB_CDEF, 10, 5, 10, 2, {1'b0, 2'd2}, "R5");

    // R5: total one past two intervals -> three rounds
    run_op(32'h0BAD_F00E, 64'h0000_0001_0000_0001, 10, 5, 11, 3, {1'b0, 2'd2}, "R5");

    // R4/R5/R10: completion appears in round 2 with request back-pressure
    stall = 1; busy_lag = 2; done_round = 2;
    run_op(32'h8000_0007, 64'h0000_0000_0000_0002, 30, 5, 20, 2, 3'b100, "R10");
    stall = 0;

    // R7: extra starts while busy are ignored
    busy_lag = 2; done_round = 1;
    fork
      run_op(32'h7777_0001, 64'h0000_0009_0000_0008, 20, 5, 20, 1, 3'b100, "R7");
      begin
        repeat (5) @(negedge clk);
        cmd = 32'hFFFF_FFFF; value = '1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    repeat (10) @(negedge clk);
    chk(!busy && !req_valid, "R7", "no restart from ignored start", {busy, req_valid}, 0);

    // R9: reset mid-operation
    busy_lag = 1000;
    @(negedge clk);
    cmd = 32'h5; value = 64'h5; busy_to = 16'd200; poll_int = 16'd5; total_to = 16'd20;
    exp_addr.push_back(A_LO); exp_data.push_back(32'h5);
    exp_addr.push_back(A_HI); exp_data.push_back(32'h0);
    exp_addr.push_back(A_CMD); exp_data.push_back(32'h5);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!busy && !done && !ok && err == 0 && !req_valid, "R9", "state after reset",
        {busy, done, ok, err, req_valid}, 0);
    rst = 1'b0;
    exp_addr.delete(); exp_data.delete();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule